// File: doc/BRIEF.md
# Error Injection Command Sequencer

This block feeds commands, one at a time, into the command port of a configuration-memory scrubbing controller. A host loads up to eight 40-bit command words into a small table, sets how many of them to run, and pulses `start`. The sequencer runs through the table in index order. For each entry it places the word on `cmd_addr` and raises `cmd_strobe` for a single clock. It then waits for the controller's status vector to show that the command was taken. After that it waits for the status to fall back to idle, and only then sends the next word. It never repeats a strobe to push a command through.

The status vector is decoded with this bit layout: bit 7 heartbeat, bit 6 initialization, bit 5 observation, bit 4 correction, bit 3 classification, bit 2 injection, bit 1 essential, bit 0 uncorrectable. The heartbeat bit is masked off, so the controller is idle when the other seven bits are all zero. Idle reads 0x00, observation reads 0x20 and injection reads 0x04. Error-injection words carry 0xC0 in their top byte. Other top-byte values request a state change. The sequencer does not decode the word and sends both kinds the same way.

While it waits, the sequencer measures how many cycles pass from the first cycle in which the injection bit is seen until the status is idle again. It stores this count for each command index in a register the host can read. If the controller never reacts to a strobe, a programmable limit ends the wait and sets a sticky error flag.

Top module: `inj_cmd_seq`

## Requirements
- R1: For each command index i from 0 to the effective count minus 1, in ascending order, `cmd_strobe` is high for exactly one clock cycle, and in that cycle `cmd_addr` equals table entry i.
- R2: After a strobe, no further strobe is issued until the masked status (bits 6..0) has become nonzero and has then returned to zero.
- R3: Bit 7 (heartbeat) of `scrub_status` is ignored. A toggling heartbeat with bits 6..0 at zero is never taken as acceptance or as activity.
- R4: For each completed command, `rd_dur` at that index reads the number of cycles in which bit 2 had been seen since the strobe and bits 6..0 were nonzero. A command that never raises bit 2 records 0.
- R5: The duration count saturates at 2^CNT_W-1 and does not wrap.
- R6: If bits 6..0 stay zero for `wait_limit` cycles after a strobe, `err` goes high and stays high. The sequence is abandoned, `busy` drops, no further strobe is issued and `done` does not pulse.
- R7: `done` pulses high for one cycle after the last command returns to idle. `busy` is high from the cycle after an accepted `start` through that pulse.
- R8: `start` has no effect while `busy` is high or when `cmd_total` is 0. A `cmd_total` above 8 is treated as 8.
- R9: Synchronous active-high `rst` returns the sequencer to idle and clears `err`, the stored durations and the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Command table write enable |
| tbl_widx | input | 3 | Table write index |
| tbl_wdata | input | 40 | Table write word |
| cmd_total | input | 4 | Number of commands to run (0..8) |
| wait_limit | input | CNT_W | Idle cycles allowed after a strobe before timeout |
| start | input | 1 | Begins a sequence |
| scrub_status | input | 8 | Controller status vector |
| cmd_addr | output | 40 | Command word to controller |
| cmd_strobe | output | 1 | One-cycle command strobe |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | Sticky timeout flag |
| rd_idx | input | 3 | Duration register select |
| rd_dur | output | CNT_W | Measured injection duration at rd_idx |

## Verification
The hardest cases to reach from the ports are saturation of the duration counter and the timeout. At the default width, saturation would need about a million injection cycles. The bench therefore builds the block with an 8-bit counter and holds the injection state for 300 cycles. For the timeout, the bench's responder stays silent while the heartbeat bit keeps toggling. The flag can only rise if that toggling is masked off, and the bench then confirms that only one strobe went out. In every run the responder checks each cycle of its busy period to confirm that no second strobe appears.

// File: rtl/inj_seq_pkg.sv
package inj_seq_pkg;

    localparam int CMD_W  = 40;
    localparam int STAT_W = 8;

    localparam int ST_HEARTBEAT = 7;
    localparam int ST_INJECT    = 2;

    localparam logic [STAT_W-1:0] STAT_MASK = 8'h7F;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_WAIT_ACK,
        SQ_WAIT_DONE,
        SQ_DONE
    } seq_state_e;

    typedef struct packed {
        logic arm;     // new command issued: clear measurement
        logic track;   // waiting on the controller
        logic commit;  // command completed: store measurement
    } meas_ctl_t;

    function automatic logic stat_idle(input logic [STAT_W-1:0] s);
        return (s & STAT_MASK) == '0;
    endfunction

    function automatic logic stat_injecting(input logic [STAT_W-1:0] s);
        return s[ST_INJECT];
    endfunction

endpackage

// File: rtl/cmd_table.sv
module cmd_table
    import inj_seq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [CMD_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CMD_W-1:0] rd_data
);

    logic [CMD_W-1:0] entry [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                entry[g] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                entry[g] <= wr_data;
            end
        end
    end

    assign rd_data = entry[rd_idx];

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import inj_seq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = 20,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [IDX_W:0]    cmd_total,
    input  logic [CNT_W-1:0]  wait_limit,
    input  logic [STAT_W-1:0] status,
    output logic [IDX_W-1:0]  idx,
    output logic              strobe,
    output logic              busy,
    output logic              done,
    output logic              err,
    output meas_ctl_t         meas
);

    seq_state_e       state;
    logic [CNT_W-1:0] timer;
    logic [IDX_W:0]   eff_total;
    logic [IDX_W-1:0] last_idx;
    logic             st_idle;

    assign eff_total = (cmd_total > (IDX_W+1)'(DEPTH)) ? (IDX_W+1)'(DEPTH) : cmd_total;
    assign last_idx  = IDX_W'(eff_total - (IDX_W+1)'(1));
    assign st_idle   = stat_idle(status);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            idx   <= '0;
            timer <= '0;
            err   <= 1'b0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (start && eff_total != '0) begin
                        idx   <= '0;
                        state <= SQ_ISSUE;
                    end
                end
                SQ_ISSUE: begin
                    timer <= '0;
                    state <= SQ_WAIT_ACK;
                end
                SQ_WAIT_ACK: begin
                    if (!st_idle) begin
                        state <= SQ_WAIT_DONE;
                    end else if (({1'b0, timer} + (CNT_W+1)'(1)) >= {1'b0, wait_limit}) begin
                        err   <= 1'b1;
                        state <= SQ_IDLE;
                    end else begin
                        timer <= timer + 1'b1;
                    end
                end
                SQ_WAIT_DONE: begin
                    if (st_idle) begin
                        if (idx == last_idx) begin
                            state <= SQ_DONE;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= SQ_ISSUE;
                        end
                    end
                end
                SQ_DONE:  state <= SQ_IDLE;
                default:  state <= SQ_IDLE;
            endcase
        end
    end

    assign strobe      = (state == SQ_ISSUE);
    assign busy        = (state != SQ_IDLE);
    assign done        = (state == SQ_DONE);
    assign meas.arm    = (state == SQ_ISSUE);
    assign meas.track  = (state == SQ_WAIT_ACK) || (state == SQ_WAIT_DONE);
    assign meas.commit = (state == SQ_WAIT_DONE) && st_idle;

    // R1
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);

    // R2
    no_early_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_WAIT_ACK && st_idle) |=> !strobe);

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    err_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> ($past(state) == SQ_WAIT_ACK && !busy));

endmodule

// File: rtl/dur_meter.sv
module dur_meter
    import inj_seq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = 20,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  meas_ctl_t         meas,
    input  logic [STAT_W-1:0] status,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [CNT_W-1:0]  rd_dur
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             seen;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] bank [DEPTH];
    logic             counting;

    assign counting = meas.track && !stat_idle(status) && (seen || stat_injecting(status));

    always_ff @(posedge clk) begin
        if (rst) begin
            seen <= 1'b0;
            cnt  <= '0;
        end else if (meas.arm) begin
            seen <= 1'b0;
            cnt  <= '0;
        end else if (counting) begin
            seen <= 1'b1;
            cnt  <= (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                bank[g] <= '0;
            end else if (meas.commit && wr_idx == IDX_W'(g)) begin
                bank[g] <= cnt;
            end
        end
    end

    assign rd_dur = bank[rd_idx];

    // R5
    dur_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_MAX && !meas.arm) |=> cnt == CNT_MAX);

    // R4
    dur_clear_chk: assert property (@(posedge clk) disable iff (rst)
        meas.arm |=> (cnt == '0 && !seen));

endmodule

// File: rtl/inj_cmd_seq.sv
module inj_cmd_seq
    import inj_seq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = 20,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tbl_we,
    input  logic [IDX_W-1:0]  tbl_widx,
    input  logic [CMD_W-1:0]  tbl_wdata,
    input  logic [IDX_W:0]    cmd_total,
    input  logic [CNT_W-1:0]  wait_limit,
    input  logic              start,
    input  logic [STAT_W-1:0] scrub_status,
    output logic [CMD_W-1:0]  cmd_addr,
    output logic              cmd_strobe,
    output logic              busy,
    output logic              done,
    output logic              err,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [CNT_W-1:0]  rd_dur
);

    logic [IDX_W-1:0] cur_idx;
    meas_ctl_t        meas;

    cmd_table #(.DEPTH(DEPTH)) u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (tbl_we),
        .wr_idx  (tbl_widx),
        .wr_data (tbl_wdata),
        .rd_idx  (cur_idx),
        .rd_data (cmd_addr)
    );

    seq_fsm #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .cmd_total  (cmd_total),
        .wait_limit (wait_limit),
        .status     (scrub_status),
        .idx        (cur_idx),
        .strobe     (cmd_strobe),
        .busy       (busy),
        .done       (done),
        .err        (err),
        .meas       (meas)
    );

    dur_meter #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_meter (
        .clk    (clk),
        .rst    (rst),
        .meas   (meas),
        .status (scrub_status),
        .wr_idx (cur_idx),
        .rd_idx (rd_idx),
        .rd_dur (rd_dur)
    );

    // R1
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_strobe && !tbl_we) |=> $stable(cmd_addr));

endmodule

// File: tb/inj_cmd_seq_bench.sv
module inj_cmd_seq_bench;

    localparam int DEPTH = 8;
    localparam int CNT_W = 8;
    localparam int NVEC  = 6;

    // {command[39:0], accept delay[7:0], injection cycles[15:0], observation cycles[15:0]}
    localparam logic [79:0] VEC [NVEC] = '{
        {40'hC000001021, 8'd2, 16'd12, 16'd0},
        {40'hC00666BC9F, 8'd1, 16'd30, 16'd5},
        {40'hA000000000, 8'd3, 16'd0,  16'd7},
        {40'hC00324A91D, 8'd4, 16'd1,  16'd0},
        {40'hC001A3F15C, 8'd2, 16'd40, 16'd20},
        {40'hC000000000, 8'd1, 16'd3,  16'd2}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             tbl_we = 1'b0;
    logic [2:0]       tbl_widx = '0;
    logic [39:0]      tbl_wdata = '0;
    logic [3:0]       cmd_total = '0;
    logic [CNT_W-1:0] wait_limit = 8'd50;
    logic             start = 1'b0;
    logic [7:0]       scrub_status;
    logic [39:0]      cmd_addr;
    logic             cmd_strobe, busy, done, err;
    logic [2:0]       rd_idx = '0;
    logic [CNT_W-1:0] rd_dur;

    logic       hb = 1'b0;
    logic [6:0] stat7 = '0;
    logic       resp_en = 1'b0;
    int tests = 0, fails = 0;
    int stb_total = 0, done_cnt = 0, stb_idx = 0, rk = 0;
    logic [39:0] exp_cmd [8];
    int rsp_delay [8], rsp_inj [8], rsp_obs [8];

    assign scrub_status = {hb, stat7};

    always #2.5 clk = ~clk;

    inj_cmd_seq #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_inj_cmd_seq (
        .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_widx(tbl_widx), .tbl_wdata(tbl_wdata),
        .cmd_total(cmd_total), .wait_limit(wait_limit), .start(start),
        .scrub_status(scrub_status), .cmd_addr(cmd_addr), .cmd_strobe(cmd_strobe),
        .busy(busy), .done(done), .err(err), .rd_idx(rd_idx), .rd_dur(rd_dur)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step_chk();
        @(negedge clk);
        if (cmd_strobe) chk("R2 strobe while controller busy", 1, 0);
    endtask

    // heartbeat toggles throughout (R3)
    always @(negedge clk) hb <= ~hb;

    always @(negedge clk) begin
        if (cmd_strobe) stb_total <= stb_total + 1;
        if (done) done_cnt <= done_cnt + 1;
    end

    // behavioural controller responder
    always begin
        @(negedge clk);
        if (cmd_strobe && resp_en) begin
            rk = stb_idx;
            stb_idx++;
            chk("R1 command word at strobe", cmd_addr, exp_cmd[rk]);
            for (int j = 0; j < rsp_delay[rk]; j++) step_chk();
            if (rsp_inj[rk] > 0) begin
                stat7 = 7'h04;
                for (int j = 0; j < rsp_inj[rk]; j++) step_chk();
            end
            if (rsp_obs[rk] > 0) begin
                stat7 = 7'h20;
                for (int j = 0; j < rsp_obs[rk]; j++) step_chk();
            end
            stat7 = 7'h00;
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic load(input int i, input logic [39:0] w);
        @(negedge clk);
        tbl_we = 1'b1; tbl_widx = 3'(i); tbl_wdata = w;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    task automatic read_dur(input int i, output logic [CNT_W-1:0] v);
        @(negedge clk);
        rd_idx = 3'(i);
        #1 v = rd_dur;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [CNT_W-1:0] d;
        int s0, d0, tot;
        tick(3);
        rst = 1'b0;
        tick(1);
        // R9 reset state
        chk("R9 strobe after reset", cmd_strobe, 0);
        chk("R9 busy after reset", busy, 0);
        chk("R9 err after reset", err, 0);
        read_dur(0, d);
        chk("R9 duration after reset", d, 0);

        // table-driven sequence
        for (int i = 0; i < NVEC; i++) begin
            exp_cmd[i]   = VEC[i][79:40];
            rsp_delay[i] = int'(VEC[i][39:32]);
            rsp_inj[i]   = int'(VEC[i][31:16]);
            rsp_obs[i]   = int'(VEC[i][15:0]);
            load(i, VEC[i][79:40]);
        end
        cmd_total = 4'(NVEC);
        resp_en = 1'b1;
        stb_idx = 0;
        s0 = stb_total; d0 = done_cnt;
        pulse_start();
        chk("R7 busy during run", busy, 1);
        wait_idle();
        tick(2);
        chk("R1 strobe count", stb_total - s0, NVEC);
        chk("R7 one done pulse", done_cnt - d0, 1);
        chk("R6 no error on normal run", err, 0);
        for (int i = 0; i < NVEC; i++) begin
            tot = (rsp_inj[i] > 0) ? rsp_inj[i] + rsp_obs[i] : 0;
            if (tot > 255) tot = 255;
            read_dur(i, d);
            chk("R4 duration", d, tot);
        end

        // R5 saturation, R8 start ignored while busy
        exp_cmd[0] = 40'hC000001021; rsp_delay[0] = 1; rsp_inj[0] = 300; rsp_obs[0] = 0;
        load(0, 40'hC000001021);
        cmd_total = 4'd1;
        stb_idx = 0;
        s0 = stb_total;
        pulse_start();
        tick(50);
        pulse_start();
        wait_idle();
        tick(2);
        chk("R8 start during busy ignored", stb_total - s0, 1);
        read_dur(0, d);
        chk("R5 saturated duration", d, 255);

        // R8 zero count
        cmd_total = 4'd0;
        s0 = stb_total;
        pulse_start();
        tick(20);
        chk("R8 zero count no strobe", stb_total - s0, 0);
        chk("R8 zero count not busy", busy, 0);

        // R6 / R3 timeout with silent controller and toggling heartbeat
        resp_en = 1'b0;
        wait_limit = 8'd10;
        cmd_total = 4'd2;
        s0 = stb_total; d0 = done_cnt;
        pulse_start();
        tick(4);
        chk("R6 no early timeout", err, 0);
        tick(30);
        chk("R3 R6 timeout despite heartbeat", err, 1);
        chk("R6 busy dropped", busy, 0);
        chk("R6 single strobe", stb_total - s0, 1);
        chk("R6 no done", done_cnt - d0, 0);
        tick(10);
        chk("R6 err sticky", err, 1);

        // R9 reset clears
        @(negedge clk); rst = 1'b1;
        tick(2); rst = 1'b0;
        tick(1);
        chk("R9 err cleared", err, 0);
        read_dur(0, d);
        chk("R9 durations cleared", d, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule